// File: doc/BRIEF.md
# Byte-wide SPI master shift engine

This block drives one serial peripheral link as bus master. Writing a byte into it starts a full-duplex exchange of eight bits at once, with no separate start command. The byte leaves on the data-out line most significant bit first while eight bits are shifted in from the data-in line. When the eighth bit period ends, the received byte lands in the read buffer and a completion flag rises. The flag stays up until the host clears it.

The bit clock comes from one of three fixed divisions of the system clock, or from an external timer whose single-cycle ticks each toggle the serial clock. The serial clock's idle level, the order of output change against clock edge, and the point where input is sampled can each be set. A separate output enable lets the link only listen: shifting and reception go on unchanged.

Top module: `spi_master_engine`

## Requirements
- R1: After reset busy, done, wcol and ovf are 0, rd_data is 0 and sck rests at the cpol level.
- R2: Data leaves on sdo most significant bit first, one bit per bit period, each bit presented from the start of its period; with lead_out=1 the first bit is on sdo in the first cycle after the write, before any sck edge.
- R3: rate_sel selects the half-period of sck: 00 = 2 system cycles (divide by 4), 01 = 8 (divide by 16), 10 = 32 (divide by 64), 11 = one tmr_tick pulse. busy stays high for exactly 16 half-periods.
- R4: sck idles at cpol. Each bit has a first and a second half; with lead_out=1 sck is at cpol in the first half and inverted in the second; with lead_out=0 it is inverted in the first half and at cpol in the second.
- R5: With smp_end=0 sdi is sampled at the end of the first half of each bit (mid-bit); with smp_end=1 at the end of the second half (end of bit).
- R6: At the end of a transfer the received byte appears on rd_data and done is set; done stays set until clr_flags is pulsed.
- R7: A wr_en while idle starts a transfer: busy is high in the next cycle.
- R8: A wr_en while busy is ignored, leaves the running transfer's sdo and received data untouched, and sets wcol.
- R9: If a transfer completes while the previous received byte is unread (no rd_en pulse since), ovf is set and rd_data keeps the old byte.
- R10: sdo_oe follows sdo_en; with sdo_en=0 reception, done and rd_data behave exactly as with it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; starts a transfer when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Marks the received byte as read |
| rd_data | output | 8 | Last accepted received byte |
| clr_flags | input | 1 | Clears done, wcol and ovf |
| rate_sel | input | 2 | Bit-rate choice, encoding in R3 |
| cpol | input | 1 | Idle level of sck |
| lead_out | input | 1 | 1: data valid before first edge of each bit |
| smp_end | input | 1 | 0: mid-bit sample, 1: end-of-bit sample |
| sdo_en | input | 1 | Data-output enable |
| tmr_tick | input | 1 | External timer pulse, used when rate_sel = 11 |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete flag |
| wcol | output | 1 | Write-while-busy flag |
| ovf | output | 1 | Receive overflow flag |

## Verification
A wrong phase bit shows within one half-period as an sck level opposite to the one R4 demands, and a stuck or skipped bit counter shows as a busy window that is not 16 half-periods long. A shift register fed at the wrong point only becomes visible at completion, as a wrong byte on rd_data; driving sdi with different values in the two halves of each bit makes a mid-bit and an end-of-bit sample give different bytes, so a swapped sample point is caught on the first transfer. A broken unread marker shows up on the second completion as a missing ovf or a replaced rd_data.

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         clr_flags,
  input  logic [1:0]   rate_sel,
  input  logic         cpol,
  input  logic         lead_out,
  input  logic         smp_end,
  input  logic         sdo_en,
  input  logic         tmr_tick,
  input  logic         sdi,
  output logic         sck,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         busy,
  output logic         done,
  output logic         wcol,
  output logic         ovf
);
  localparam int CW = $clog2(DIV_C / 2) + 1;
  localparam int BW = $clog2(W);

  logic [CW-1:0] cnt, lim;
  logic [BW-1:0] bitcnt;
  logic          phase, unread;
  logic [W-1:0]  tx, rx;

  always_comb begin
    case (rate_sel)
      2'd0:    lim = CW'(DIV_A / 2 - 1);
      2'd1:    lim = CW'(DIV_B / 2 - 1);
      2'd2:    lim = CW'(DIV_C / 2 - 1);
      default: lim = '0;
    endcase
  end

  wire          adv     = busy && ((rate_sel == 2'd3) ? tmr_tick : (cnt == lim));
  wire          fin     = adv && phase && (bitcnt == BW'(W - 1));
  wire          start   = wr_en && !busy;
  wire [W-1:0]  rx_next = {rx[W-2:0], sdi};
  wire [W-1:0]  rx_fin  = smp_end ? rx_next : rx;

  assign sck    = busy ? (cpol ^ (lead_out ? phase : ~phase)) : cpol;
  assign sdo    = tx[W-1];
  assign sdo_oe = sdo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; phase <= 1'b0; bitcnt <= '0;
      tx <= '0; rx <= '0;
    end else if (start) begin
      busy <= 1'b1; tx <= wr_data; cnt <= '0; phase <= 1'b0; bitcnt <= '0;
    end else if (busy) begin
      cnt <= adv ? '0 : cnt + 1'b1;
      if (adv) begin
        if (!phase) begin
          phase <= 1'b1;
          if (!smp_end) rx <= rx_next;
        end else begin
          phase <= 1'b0;
          if (smp_end) rx <= rx_next;
          if (fin) busy <= 1'b0;
          else begin
            bitcnt <= bitcnt + 1'b1;
            tx     <= {tx[W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; unread <= 1'b0; done <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else begin
      if (clr_flags) begin done <= 1'b0; wcol <= 1'b0; ovf <= 1'b0; end
      if (rd_en) unread <= 1'b0;
      if (wr_en && busy) wcol <= 1'b1;
      if (fin) begin
        done <= 1'b1;
        if (unread) ovf <= 1'b1;
        else begin
          rd_data <= rx_fin;
          unread  <= 1'b1;
        end
      end
    end
  end

  a_r7_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);
  a_r8_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_flags) |=> done);
  a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && unread) |=> (ovf && $stable(rd_data)));
  a_r3_tick_paces: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rate_sel == 2'd3 && !tmr_tick && !wr_en) |=> $stable(sck));
endmodule

// File: tb/spi_master_engine_tb_top.sv
module spi_master_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, clr_flags = 0, cpol = 0, lead_out = 0, smp_end = 0;
  logic sdo_en = 1, tmr_tick = 0, sdi = 0;
  logic [1:0] rate_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic sck, sdo, sdo_oe, busy, done, wcol, ovf;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_master_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .clr_flags(clr_flags), .rate_sel(rate_sel), .cpol(cpol),
    .lead_out(lead_out), .smp_end(smp_end), .sdo_en(sdo_en), .tmr_tick(tmr_tick),
    .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .done(done),
    .wcol(wcol), .ovf(ovf));

  // {rate, cpol, lead_out, smp_end, tx, sdi first half, sdi second half}
  localparam logic [28:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hC3},
    {2'd0, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h0F, 8'hE1},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h96, 8'h69},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h7E, 8'h12, 8'hED},
    {2'd2, 1'b0, 1'b1, 1'b1, 8'hC9, 8'hFF, 8'h4B},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h36, 8'hB2, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [28:0] v, input bit inj, input bit chk_rx);
    logic [7:0] tx, a, b, exp_rx;
    int h, n, idx, ticks, sck_bad, sdo_bad, len;
    {rate_sel, cpol, lead_out, smp_end, tx, a, b} = v;
    h = (v[28:27] == 2'd0) ? 2 : (v[28:27] == 2'd1) ? 8 : 32;
    for (int i = 0; i < 8; i++) exp_rx[7-i] = smp_end ? b[7-i] : a[7-i];
    wr_data = tx; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    check(busy === 1'b1, "R7 busy after write", busy, 1);
    n = 0; ticks = 0; sck_bad = 0; sdo_bad = 0; len = 0;
    while (busy && n < 2000) begin
      idx = (rate_sel == 2'd3) ? ticks : n / h;
      len++;
      if (sck !== (cpol ^ (lead_out ? idx[0] : ~idx[0]))) sck_bad++;
      if (sdo !== tx[7 - idx/2]) sdo_bad++;
      sdi = idx[0] ? b[7 - idx/2] : a[7 - idx/2];
      tmr_tick = (rate_sel == 2'd3) && (n % 3 == 2);
      if (tmr_tick) ticks++;
      wr_en = inj && (n == 5);
      wr_data = inj ? 8'hFF : tx;
      n++;
      @(negedge clk);
    end
    tmr_tick = 0; wr_en = 0;
    check(len == ((rate_sel == 2'd3) ? 48 : 16 * h), "R3 busy length", len,
          (rate_sel == 2'd3) ? 48 : 16 * h);
    check(sck_bad == 0, "R4 sck shape", sck_bad, 0);
    check(sdo_bad == 0, "R2 sdo order", sdo_bad, 0);
    check(done === 1'b1, "R6 done set", done, 1);
    if (chk_rx) check(rd_data === exp_rx, "R5 received byte", rd_data, exp_rx);
    repeat (4) @(negedge clk);
    check(done === 1'b1, "R6 done held", done, 1);
  endtask

  task automatic clear_all();
    rd_en = 1; clr_flags = 1;
    @(negedge clk);
    rd_en = 0; clr_flags = 0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 0 && done === 0 && wcol === 0 && ovf === 0, "R1 flags", {busy, done, wcol, ovf}, 0);
    check(rd_data === 8'h00, "R1 rd_data", rd_data, 0);
    check(sck === 1'b0, "R1 sck idle", sck, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      run(VEC[i], 1'b0, 1'b1);
      clear_all();
      check(done === 1'b0, "R6 done cleared", done, 0);
    end

    // R4 idle level with cpol=1
    cpol = 1;
    @(negedge clk);
    check(sck === 1'b1, "R4 idle high", sck, 1);

    // R8 write while busy
    run({2'd0, 1'b0, 1'b1, 1'b0, 8'h4D, 8'h77, 8'h00}, 1'b1, 1'b1);
    check(wcol === 1'b1, "R8 wcol set", wcol, 1);
    clear_all();
    check(wcol === 1'b0, "R8 wcol cleared", wcol, 0);

    // R9 overflow keeps old byte
    run({2'd0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h00, 8'h9C}, 1'b0, 1'b1);
    run({2'd0, 1'b0, 1'b0, 1'b1, 8'h22, 8'h00, 8'h35}, 1'b0, 1'b0);
    check(ovf === 1'b1, "R9 ovf set", ovf, 1);
    check(rd_data === 8'h9C, "R9 old byte kept", rd_data, 8'h9C);
    clear_all();

    // R10 receive-only
    sdo_en = 0;
    @(negedge clk);
    check(sdo_oe === 1'b0, "R10 sdo_oe low", sdo_oe, 0);
    run({2'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hD4, 8'h2B}, 1'b0, 1'b1);
    check(ovf === 1'b0, "R10 no overflow", ovf, 0);
    clear_all();
    sdo_en = 1;
    @(negedge clk);
    check(sdo_oe === 1'b1, "R10 sdo_oe high", sdo_oe, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule